// File: doc/BRIEF.md
# Dual Wiper Register Command Engine

This block is the command layer behind a serial slave for a pair of 64-position digital potentiometers. Each pot has a 6-bit volatile wiper code, which drives the resistor ladder, and a bank of four 6-bit nonvolatile setting registers. The serial front end detects start and stop conditions and matches the device address. It then hands this engine the bytes that follow the address as a valid/ready byte stream. The engine decodes the first byte as an instruction. It executes reads, writes, single transfers, global transfers across both pots, and a step mode that moves a wiper one position per pulse.

Any change to a setting register is held pending until the stop condition. The engine then starts a programming cycle of `WR_CYCLES` clocks, which the stored array models. For that whole window `busy` is high and the engine takes no bytes and no new frames. The array contents survive the logic reset `rst_n` and are initialised only by the power-on reset `por_n`. After every logic reset, each wiper reloads itself from setting register 0 of its own pot.

Byte stream rules: a byte on `rx_data` is consumed on a clock edge where `rx_valid` and `rx_ready` are both high and `stop_evt` is low. `rx_ready` is low while `busy` is high, while a read response is pending and during the recall cycle. A read response is offered on `rd_data` with `rd_valid`. It holds, unchanged, until the receiver raises `rd_ready`.

Top module: `wiper_cmd_engine`

## Requirements
- R1: On leaving logic reset, each wiper is loaded with setting register 0 of its own pot. With power-on defaults these are 33 for pot 0 and 20 for pot 1. A logic reset alone keeps the setting registers, so any value committed before the reset is what gets recalled.
- R2: The instruction byte carries the opcode in bits 7:4, a required zero in bit 3, the pot select in bit 2 and the setting register select in bits 1:0. Opcode 1010 followed by a data byte loads bits 5:0 of that byte into the selected wiper at once, and `busy` stays low.
- R3: Opcode 1001 returns the selected wiper, and opcode 1011 returns the selected setting register. Each is returned as one response byte with bits 7:6 zero.
- R4: Opcode 1100 followed by a data byte schedules bits 5:0 for the selected setting register. Nothing is committed and `busy` stays low until the stop condition.
- R5: A stop with a pending commit raises `busy` on the next cycle for exactly `WR_CYCLES` cycles. During that window `rx_ready` is low and a frame start is ignored. The new value becomes readable once `busy` has fallen.
- R6: Opcode 1101 copies the selected setting register into the selected wiper as soon as the instruction is taken, without a programming cycle.
- R7: Opcode 1110 schedules a copy of the selected wiper into the selected setting register of the same pot. The copy is committed at stop, with a `busy` window.
- R8: Opcode 0001 copies setting register R of each pot into that pot's wiper at once. R is taken from bits 1:0.
- R9: Opcode 1000 schedules a copy of both wipers into setting register R of their own pots. The copy is committed at stop, with one `busy` window.
- R10: After opcode 0010, each `step_pulse` moves the selected wiper one position up when `step_up` is 1 and down when it is 0. The code saturates at 63 and at 0. Step pulses outside this mode have no effect.
- R11: An undefined opcode, an instruction with bit 3 set, and a byte after a two-byte instruction are all consumed and ignored. No register changes and no `busy` window starts.
- R12: A stop that arrives before the data byte of a write, or in the same cycle as that byte, drops the write. Nothing is written and no programming cycle starts.
- R13: While `rd_ready` is low, `rd_valid` stays high and `rd_data` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset of the setting register array, active low |
| rst_n | input | 1 | Logic reset, active low; triggers wiper recall |
| sess_start | input | 1 | Pulse: start condition with matching address seen |
| rx_valid | input | 1 | Received byte valid |
| rx_ready | output | 1 | Engine accepts a received byte |
| rx_data | input | 8 | Received byte (instruction or data) |
| stop_evt | input | 1 | Pulse: stop condition seen |
| step_pulse | input | 1 | One wiper step in step mode |
| step_up | input | 1 | Step direction: 1 up, 0 down |
| rd_valid | output | 1 | Read response valid |
| rd_ready | input | 1 | Receiver takes the read response |
| rd_data | output | 8 | Read response byte |
| busy | output | 1 | Programming cycle in progress |
| wiper0 | output | 6 | Wiper code of pot 0 |
| wiper1 | output | 6 | Wiper code of pot 1 |

## Verification
Two events can land on the same clock edge: the stop condition and the data byte of a write. The engine gives the stop priority. The bench provokes the collision by raising `rx_valid` and `stop_evt` together on one edge. It then checks at the ports that the wiper did not move and that `busy` never rose. A second case presses a frame start and a byte against a running `busy` window. The bench judges it by seeing the later orphan bytes leave the wipers untouched.

// File: rtl/wcmd_pkg.sv
package wcmd_pkg;
  localparam int N_POTS    = 2;
  localparam int N_REGS    = 4;
  localparam int WIPER_W   = 6;
  localparam int BYTE_W    = 8;
  localparam int POT_SEL_W = (N_POTS > 1) ? $clog2(N_POTS) : 1;
  localparam int REG_SEL_W = $clog2(N_REGS);
  localparam int NV_BITS   = N_POTS * N_REGS * WIPER_W;

  typedef logic [WIPER_W-1:0] code_t;
  typedef logic [N_POTS-1:0][WIPER_W-1:0] code_vec_t;
  typedef logic [N_POTS-1:0][N_REGS-1:0][WIPER_W-1:0] nv_mem_t;

  typedef enum logic [3:0] {
    OP_GLB_DR2W = 4'b0001,
    OP_STEP     = 4'b0010,
    OP_GLB_W2DR = 4'b1000,
    OP_RD_W     = 4'b1001,
    OP_WR_W     = 4'b1010,
    OP_RD_DR    = 4'b1011,
    OP_WR_DR    = 4'b1100,
    OP_DR2W     = 4'b1101,
    OP_W2DR     = 4'b1110
  } opcode_e;

  typedef struct packed {
    logic                 known;
    opcode_e              op;
    logic [POT_SEL_W-1:0] pot;
    logic [REG_SEL_W-1:0] rsel;
  } instr_t;

  typedef enum logic [2:0] {
    S_RECALL, S_IDLE, S_INSTR, S_DATA, S_RESP, S_STEP, S_DONE
  } state_e;
endpackage

// File: rtl/wcmd_decode.sv
module wcmd_decode
  import wcmd_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  output instr_t            ins
);
  always_comb begin
    ins.op   = opcode_e'(byte_i[7:4]);
    ins.pot  = byte_i[2 -: POT_SEL_W];
    ins.rsel = byte_i[REG_SEL_W-1:0];
    case (byte_i[7:4])
      OP_GLB_DR2W, OP_STEP, OP_GLB_W2DR, OP_RD_W, OP_WR_W,
      OP_RD_DR, OP_WR_DR, OP_DR2W, OP_W2DR: ins.known = !byte_i[3];
      default:                               ins.known = 1'b0;
    endcase
  end
endmodule

// File: rtl/wcmd_wiper.sv
module wcmd_wiper
  import wcmd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ld_en,
  input  code_t ld_val,
  input  logic  step_en,
  input  logic  step_up,
  output code_t code
);
  localparam code_t CODE_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= '0;
    end else if (ld_en) begin
      code <= ld_val;
    end else if (step_en) begin
      if (step_up && code != CODE_MAX)  code <= code + 1'b1;
      else if (!step_up && code != '0)  code <= code - 1'b1;
    end
  end
endmodule

// File: rtl/wcmd_nvarray.sv
module wcmd_nvarray
  import wcmd_pkg::*;
#(
  parameter int                  WR_CYCLES = 64,
  parameter logic [NV_BITS-1:0]  DR_INIT   = '0
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 rst_n,
  input  logic                 commit_go,
  input  logic [N_POTS-1:0]    commit_mask,
  input  logic [REG_SEL_W-1:0] commit_idx,
  input  code_vec_t            commit_val,
  output logic                 busy,
  output nv_mem_t              mem_q
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  logic [CNT_W-1:0]     cnt;
  logic [N_POTS-1:0]    mask_q;
  logic [REG_SEL_W-1:0] idx_q;
  code_vec_t            val_q;
  logic                 finish;

  assign finish = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      mask_q <= '0;
      idx_q  <= '0;
      val_q  <= '0;
    end else if (commit_go && !busy) begin
      busy   <= 1'b1;
      cnt    <= CNT_W'(WR_CYCLES - 1);
      mask_q <= commit_mask;
      idx_q  <= commit_idx;
      val_q  <= commit_val;
    end else if (finish) begin
      busy   <= 1'b0;
    end else if (busy) begin
      cnt    <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mem_q <= nv_mem_t'(DR_INIT);
    end else if (finish) begin
      for (int p = 0; p < N_POTS; p++)
        if (mask_q[p]) mem_q[p][idx_q] <= val_q[p];
    end
  end
endmodule

// File: rtl/wiper_cmd_engine.sv
module wiper_cmd_engine
  import wcmd_pkg::*;
#(
  parameter int                 WR_CYCLES = 64,
  parameter logic [NV_BITS-1:0] DR_INIT   =
    {6'd7, 6'd6, 6'd5, 6'd20, 6'd3, 6'd2, 6'd1, 6'd33}
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               rst_n,
  input  logic               sess_start,
  input  logic               rx_valid,
  output logic               rx_ready,
  input  logic [BYTE_W-1:0]  rx_data,
  input  logic               stop_evt,
  input  logic               step_pulse,
  input  logic               step_up,
  output logic               rd_valid,
  input  logic               rd_ready,
  output logic [BYTE_W-1:0]  rd_data,
  output logic               busy,
  output logic [WIPER_W-1:0] wiper0,
  output logic [WIPER_W-1:0] wiper1
);
  state_e               st;
  opcode_e              cur_op;
  logic [POT_SEL_W-1:0] cur_pot;
  logic [REG_SEL_W-1:0] cur_rsel;
  logic [BYTE_W-1:0]    rd_q;
  logic [N_POTS-1:0]    pend_mask;
  logic [REG_SEL_W-1:0] pend_idx;
  code_vec_t            pend_val;

  instr_t            dec;
  nv_mem_t           mem;
  code_vec_t         wq;
  code_vec_t         ld_val;
  logic [N_POTS-1:0] ld_en;
  logic [N_POTS-1:0] step_en;
  logic              rx_fire;
  logic              commit_go;

  wcmd_decode u_dec (.byte_i(rx_data), .ins(dec));

  assign rx_ready  = !busy && (st != S_RESP) && (st != S_RECALL);
  assign rx_fire   = rx_valid && rx_ready && !stop_evt;
  assign commit_go = stop_evt && (|pend_mask) && (st != S_RECALL);
  assign rd_valid  = (st == S_RESP);
  assign rd_data   = rd_q;
  assign wiper0    = wq[0];
  assign wiper1    = wq[1];

  wcmd_nvarray #(.WR_CYCLES(WR_CYCLES), .DR_INIT(DR_INIT)) u_nv (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .commit_go(commit_go), .commit_mask(pend_mask),
    .commit_idx(pend_idx), .commit_val(pend_val),
    .busy(busy), .mem_q(mem)
  );

  // Volatile wiper updates: recall, transfers, host writes, steps
  always_comb begin
    ld_en   = '0;
    ld_val  = '0;
    step_en = '0;
    if (st == S_RECALL) begin
      for (int p = 0; p < N_POTS; p++) begin
        ld_en[p]  = 1'b1;
        ld_val[p] = mem[p][0];
      end
    end else if (st == S_INSTR && rx_fire && dec.known) begin
      if (dec.op == OP_DR2W) begin
        ld_en[dec.pot]  = 1'b1;
        ld_val[dec.pot] = mem[dec.pot][dec.rsel];
      end else if (dec.op == OP_GLB_DR2W) begin
        for (int p = 0; p < N_POTS; p++) begin
          ld_en[p]  = 1'b1;
          ld_val[p] = mem[p][dec.rsel];
        end
      end
    end else if (st == S_DATA && rx_fire && cur_op == OP_WR_W) begin
      ld_en[cur_pot]  = 1'b1;
      ld_val[cur_pot] = rx_data[WIPER_W-1:0];
    end else if (st == S_STEP && step_pulse && !stop_evt) begin
      step_en[cur_pot] = 1'b1;
    end
  end

  for (genvar p = 0; p < N_POTS; p++) begin : g_wiper
    wcmd_wiper u_wiper (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en[p]), .ld_val(ld_val[p]),
      .step_en(step_en[p]), .step_up(step_up), .code(wq[p])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_RECALL;
      cur_op    <= OP_RD_W;
      cur_pot   <= '0;
      cur_rsel  <= '0;
      rd_q      <= '0;
      pend_mask <= '0;
      pend_idx  <= '0;
      pend_val  <= '0;
    end else if (stop_evt) begin
      st        <= (st == S_RECALL) ? S_RECALL : S_IDLE;
      pend_mask <= '0;
    end else begin
      case (st)
        S_RECALL: st <= S_IDLE;
        S_IDLE: begin
          if (sess_start && !busy) begin
            st        <= S_INSTR;
            pend_mask <= '0;
          end
        end
        S_INSTR: begin
          if (rx_fire) begin
            cur_op   <= dec.op;
            cur_pot  <= dec.pot;
            cur_rsel <= dec.rsel;
            st       <= S_DONE;
            if (dec.known) begin
              case (dec.op)
                OP_RD_W: begin
                  rd_q <= BYTE_W'(wq[dec.pot]);
                  st   <= S_RESP;
                end
                OP_RD_DR: begin
                  rd_q <= BYTE_W'(mem[dec.pot][dec.rsel]);
                  st   <= S_RESP;
                end
                OP_WR_W, OP_WR_DR: st <= S_DATA;
                OP_STEP:           st <= S_STEP;
                OP_W2DR: begin
                  pend_mask[dec.pot] <= 1'b1;
                  pend_idx           <= dec.rsel;
                  pend_val[dec.pot]  <= wq[dec.pot];
                end
                OP_GLB_W2DR: begin
                  pend_mask <= '1;
                  pend_idx  <= dec.rsel;
                  pend_val  <= wq;
                end
                default: ;
              endcase
            end
          end
        end
        S_DATA: begin
          if (rx_fire) begin
            if (cur_op == OP_WR_DR) begin
              pend_mask[cur_pot] <= 1'b1;
              pend_idx           <= cur_rsel;
              pend_val[cur_pot]  <= rx_data[WIPER_W-1:0];
            end
            st <= S_DONE;
          end
        end
        S_RESP:  if (rd_ready) st <= S_DONE;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/wcmd_checker.sv
module wcmd_checker #(
  parameter int WR_CYCLES = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       stop_evt,
  input logic       rx_ready,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       busy
);
  int busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= 0;
    else if (busy) busy_cnt <= busy_cnt + 1;
    else           busy_cnt <= 0;
  end

  a_r5_busy_blocks_rx: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rx_ready);

  a_r4_busy_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_evt));

  a_r5_busy_window_max: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> busy_cnt < WR_CYCLES);

  a_r5_busy_window_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_cnt == WR_CYCLES);

  a_r13_resp_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !stop_evt) |=> (rd_valid && $stable(rd_data)));

  a_r5_no_resp_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rd_valid);
endmodule

bind wiper_cmd_engine wcmd_checker #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_evt(stop_evt), .rx_ready(rx_ready),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .busy(busy)
);

// File: tb/wiper_cmd_engine_bench.sv
module wiper_cmd_engine_bench;
  localparam int WR = 12;

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b0;
  logic sess_start = 1'b0, rx_valid = 1'b0, stop_evt = 1'b0;
  logic step_pulse = 1'b0, step_up = 1'b0, rd_ready = 1'b1;
  logic [7:0] rx_data = '0;
  logic rx_ready, rd_valid, busy;
  logic [7:0] rd_data;
  logic [5:0] wiper0, wiper1;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [5:0] mw[2];
  logic [5:0] md[2][4];

  always #2 clk = ~clk;

  wiper_cmd_engine #(.WR_CYCLES(WR)) u_wiper_cmd_engine (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .sess_start(sess_start),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .stop_evt(stop_evt), .step_pulse(step_pulse), .step_up(step_up),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .busy(busy), .wiper0(wiper0), .wiper1(wiper1)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_wipers(input string tag);
    check({tag, " wiper0"}, wiper0, mw[0]);
    check({tag, " wiper1"}, wiper1, mw[1]);
  endtask

  // Monitor: pops the scoreboard as responses are handed over
  always @(negedge clk) begin
    if (rd_valid && rd_ready) begin
      if (exp_q.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL R3 unexpected response: actual %0d expected none", rd_data);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  task automatic start_frame();
    @(negedge clk); sess_start = 1'b1;
    @(negedge clk); sess_start = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    while (!rx_ready) @(negedge clk);
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic send_stop();
    @(negedge clk); stop_evt = 1'b1;
    @(negedge clk); stop_evt = 1'b0;
  endtask

  function automatic logic [7:0] ins(input logic [3:0] op, input int p, input int r);
    return {op, 1'b0, 1'(p), 2'(r)};
  endfunction

  // Called right after a committing stop: measures the programming window
  task automatic nv_window(input string tag);
    int n = 0;
    check({tag, " busy at stop"}, busy, 1);
    check("R5 rx_ready low in window", rx_ready, 0);
    sess_start = 1'b1;
    while (busy) begin
      n++;
      @(negedge clk);
      sess_start = 1'b0;
    end
    sess_start = 1'b0;
    check("R5 window length", n, WR);
  endtask

  task automatic read_reg(input string tag, input bit is_dr, input int p, input int r);
    exp_q.push_back(is_dr ? {2'b00, md[p][r]} : {2'b00, mw[p]});
    tag_q.push_back(tag);
    start_frame();
    send_byte(ins(is_dr ? 4'b1011 : 4'b1001, p, r));
    while (exp_q.size() != 0) @(negedge clk);
    send_stop();
  endtask

  task automatic write_wiper(input int p, input logic [7:0] v);
    start_frame(); send_byte(ins(4'b1010, p, 0)); send_byte(v); send_stop();
    mw[p] = v[5:0];
  endtask

  initial begin
    md[0] = '{6'd33, 6'd1, 6'd2, 6'd3};
    md[1] = '{6'd20, 6'd5, 6'd6, 6'd7};
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    repeat (2) @(negedge clk);
    mw[0] = md[0][0]; mw[1] = md[1][0];
    check_wipers("R1 recall at reset");
    check("R5 idle busy", busy, 0);

    read_reg("R3 read setting p1 r2", 1, 1, 2);
    read_reg("R3 read wiper p0", 0, 0, 0);

    write_wiper(1, 8'hC5);
    check_wipers("R2 write wiper low bits");
    check("R2 no busy", busy, 0);

    start_frame(); send_byte(ins(4'b1100, 0, 3)); send_byte(8'h7E);
    repeat (2) @(negedge clk);
    check("R4 busy before stop", busy, 0);
    send_stop();
    md[0][3] = 6'h3E;
    nv_window("R4");
    send_byte(ins(4'b1010, 0, 0)); send_byte(8'h00); send_stop();
    check_wipers("R5 start during busy ignored");
    read_reg("R5 setting p0 r3 after commit", 1, 0, 3);

    start_frame(); send_byte(ins(4'b1101, 0, 3)); send_stop();
    mw[0] = md[0][3];
    check_wipers("R6 setting to wiper");
    check("R6 no busy", busy, 0);

    start_frame(); send_byte(ins(4'b1110, 1, 1)); send_stop();
    md[1][1] = mw[1];
    nv_window("R7");
    read_reg("R7 wiper to setting p1 r1", 1, 1, 1);

    start_frame(); send_byte({4'b0001, 4'b0010}); send_stop();
    mw[0] = md[0][2]; mw[1] = md[1][2];
    check_wipers("R8 global to wipers");

    write_wiper(0, 8'd61);
    start_frame(); send_byte({4'b1000, 4'b0000}); send_stop();
    md[0][0] = mw[0]; md[1][0] = mw[1];
    nv_window("R9");
    read_reg("R9 global p0 r0", 1, 0, 0);
    read_reg("R9 global p1 r0", 1, 1, 0);

    start_frame(); send_byte(ins(4'b0010, 0, 0));
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); step_pulse = 1'b1; step_up = 1'b1;
      @(negedge clk); step_pulse = 1'b0;
    end
    send_stop();
    mw[0] = 6'd63;
    check_wipers("R10 step up saturates");
    start_frame(); send_byte(ins(4'b0010, 1, 0));
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); step_pulse = 1'b1; step_up = 1'b0;
      @(negedge clk); step_pulse = 1'b0;
    end
    send_stop();
    mw[1] = 6'd0;
    check_wipers("R10 step down saturates");
    @(negedge clk); step_pulse = 1'b1; step_up = 1'b1;
    @(negedge clk); step_pulse = 1'b0;
    check_wipers("R10 step outside mode");

    start_frame(); send_byte(8'h50); send_byte(8'h15); send_stop();
    check_wipers("R11 undefined opcode");
    check("R11 no busy", busy, 0);
    start_frame(); send_byte({4'b1010, 4'b1000}); send_byte(8'h15); send_stop();
    check_wipers("R11 bit3 set");
    start_frame(); send_byte(ins(4'b1101, 0, 1)); send_byte(8'h3F); send_stop();
    mw[0] = md[0][1];
    check_wipers("R11 extra byte after transfer");

    start_frame(); send_byte(ins(4'b1100, 1, 3)); send_stop();
    check("R12 early stop no busy", busy, 0);
    read_reg("R12 setting p1 r3 kept", 1, 1, 3);
    start_frame(); send_byte(ins(4'b1010, 0, 0));
    @(negedge clk); rx_valid = 1'b1; rx_data = 8'h11; stop_evt = 1'b1;
    @(negedge clk); rx_valid = 1'b0; stop_evt = 1'b0;
    check_wipers("R12 stop with data byte");
    check("R12 no busy", busy, 0);

    rd_ready = 1'b0;
    exp_q.push_back({2'b00, mw[1]}); tag_q.push_back("R13 held response");
    start_frame(); send_byte(ins(4'b1001, 1, 0));
    repeat (3) @(negedge clk);
    check("R13 valid held", rd_valid, 1);
    check("R13 data held", rd_data, {2'b00, mw[1]});
    rd_ready = 1'b1;
    while (exp_q.size() != 0) @(negedge clk);
    send_stop();

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    mw[0] = md[0][0]; mw[1] = md[1][0];
    check_wipers("R1 recall after warm reset");

    check("R3 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule